// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which power state a small system-on-chip is in and drives the control lines that follow from that state. There are three main states. In Operating everything is clocked. In Idle the CPU clock is gated but the peripherals keep running. In Standby the main oscillator/PLL enable is off and only the always-on low-frequency domain keeps running. Two transient states sit between them. One waits for DRAM to confirm self-refresh before the clock stops. The other lets the PLL settle before clocks are released again.

Software asks for Idle or Standby with single-cycle request pulses. Leaving Idle takes any enabled interrupt line. Leaving Standby depends on how Standby was entered. After a hardware reset, either power-on or user, only a rising edge on the wake pin is accepted. After a software request, either a wake edge or any enabled interrupt line is accepted. The block runs on the always-on clock. The interrupt lines arrive already masked and synchronous to that clock. The wake pin is asynchronous.

All control and status pins are plain levels; there is no streaming data interface.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `por_n_i` is low the outputs take the reset pattern at once, without waiting for a clock edge, and the state is Standby entered by hardware reset. The reset pattern is: `run_o`=0, `clk_en_o`=0, `cpu_clk_en_o`=0, `selfref_req_o`=0, `dram_en_o`=0, `periph_en_o`=0x100 and `periph_rst_o`=0x6FF.
- R2: In Standby entered by a hardware reset, interrupt lines have no effect. `run_o` stays 0 until a wake edge arrives.
- R3: In Standby entered by a software request, either a wake edge or any high bit of `irq_i` starts the exit. The exit begins on the next clock edge after the bit is seen.
- R4: `run_o` is 0 exactly when the state is Standby, and `bus_force_low_o` is always the inverse of `run_o`. `clk_en_o` is also 0 in Standby.
- R5: Peripheral bit positions are: 0 UART, 1 LCD FIFO, 2 LCD, 3 ADC, 4 serial port, 5 codec, 6 timers, 7 DC-DC, 8 RTC, 9 LED flasher, 10 interrupt controller. In Standby entered by software request, `periph_en_o`=0x700 and `periph_rst_o`=0x002. In Operating and Idle, `periph_en_o`=0x7FF and `periph_rst_o`=0.
- R6: A Standby request with `dram_refresh_en_i`=1 enters a wait state first. In that state `selfref_req_o`=1 and `clk_en_o`=1. The clock stops only on the edge after `selfref_ack_i` is seen. `selfref_req_o` stays 1 through Standby and settling, and drops on return to Operating.
- R7: If no acknowledge arrives, the wait state lasts exactly SREF_TO cycles before Standby is entered.
- R8: A one-cycle `user_rst_i` forces Standby entered by hardware reset on the next edge, with the reset pattern. In this case `selfref_req_o`=1 and `dram_en_o`=1.
- R9: The wake pin passes through two synchronizer flops, and only a 0-to-1 transition counts. A wake input raised after edge k makes the state leave Standby at edge k+3. A level that is held high causes no further exit.
- R10: After leaving Standby, `clk_en_o` and `run_o` are 1 while the peripherals keep the Standby pattern and `cpu_clk_en_o` stays 0. This lasts for `settle_cnt_i`+1 cycles, and then the state is Operating.
- R11: A `req_idle_i` in Operating gates `cpu_clk_en_o` and keeps the peripherals running, and any high bit of `irq_i` returns to Operating. An Idle request made while waiting for self-refresh is ignored.
- R12: When Standby and Idle are requested in the same cycle, Standby wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| user_rst_i | input | 1 | Synchronous user reset |
| req_idle_i | input | 1 | Software request pulse for Idle |
| req_standby_i | input | 1 | Software request pulse for Standby |
| wake_i | input | 1 | Asynchronous wake pin |
| irq_i | input | NIRQ | Masked interrupt lines |
| dram_refresh_en_i | input | 1 | DRAM refresh enabled |
| selfref_ack_i | input | 1 | DRAM self-refresh acknowledge |
| settle_cnt_i | input | SETTLE_W | PLL settle length minus one, in cycles |
| run_o | output | 1 | High outside Standby |
| clk_en_o | output | 1 | Main oscillator/PLL enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| periph_en_o | output | 11 | Per-peripheral enable |
| periph_rst_o | output | 11 | Per-peripheral reset |
| bus_force_low_o | output | 1 | Force external address/data low |
| selfref_req_o | output | 1 | DRAM self-refresh request |
| dram_en_o | output | 1 | DRAM controller enable |

## Verification
The bench builds the block with NIRQ=4, SETTLE_W=4 and SREF_TO=8. The short timeout lets the bench count the wait state edge by edge when no acknowledge arrives. The settle count can be 0, which gives the shortest exit path, or 3, where the gated cycles before Operating can be counted exactly. Four interrupt lines are enough to show that a single non-zero bit wakes the block from software Standby and that the same bit is ignored after a reset.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_OPER   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_SREF   = 3'd2,
    ST_STBY   = 3'd3,
    ST_SETTLE = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_STBY  = 2'd1,
    PM_RESET = 2'd2
  } pmode_e;

  localparam int NPERIPH = 11;

  localparam int P_UART    = 0;
  localparam int P_LCDFIFO = 1;
  localparam int P_LCD     = 2;
  localparam int P_ADC     = 3;
  localparam int P_SERIAL  = 4;
  localparam int P_CODEC   = 5;
  localparam int P_TIMER   = 6;
  localparam int P_DCDC    = 7;
  localparam int P_RTC     = 8;
  localparam int P_LED     = 9;
  localparam int P_INTC    = 10;

  // Peripherals that keep running in software Standby.
  localparam logic [NPERIPH-1:0] STBY_EN_MASK =
    (NPERIPH'(1) << P_RTC) | (NPERIPH'(1) << P_LED) | (NPERIPH'(1) << P_INTC);
  // Peripherals held in reset in software Standby.
  localparam logic [NPERIPH-1:0] STBY_RST_MASK = NPERIPH'(1) << P_LCDFIFO;
  // Only the RTC survives a hardware reset.
  localparam logic [NPERIPH-1:0] RESET_EN_MASK = NPERIPH'(1) << P_RTC;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic wake_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= wake_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q & ~s3_q;

  // A held level must give a single wake event.
  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    edge_o |=> !edge_o);

endmodule

// File: rtl/pwr_down_counter.sv
module pwr_down_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // Timeout and settle windows must never wrap around.
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dec_i && !load_i) |-> !zero_o);

endmodule

// File: rtl/pwr_periph_map.sv
module pwr_periph_map
  import pwr_seq_pkg::*;
(
  input  pmode_e              mode_i,
  output logic [NPERIPH-1:0]  en_o,
  output logic [NPERIPH-1:0]  rst_o
);
  for (genvar i = 0; i < NPERIPH; i++) begin : g_bit
    logic en_b, rst_b;
    always_comb begin
      unique case (mode_i)
        PM_RUN:  begin en_b = 1'b1;            rst_b = 1'b0;              end
        PM_STBY: begin en_b = STBY_EN_MASK[i]; rst_b = STBY_RST_MASK[i];  end
        default: begin en_b = RESET_EN_MASK[i]; rst_b = !RESET_EN_MASK[i]; end
      endcase
    end
    assign en_o[i]  = en_b;
    assign rst_o[i] = rst_b;
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NIRQ     = 4,
  parameter int SETTLE_W = 4,
  parameter int SREF_TO  = 8
) (
  input  logic                clk_i,
  input  logic                por_n_i,
  input  logic                user_rst_i,
  input  logic                req_idle_i,
  input  logic                req_standby_i,
  input  logic                wake_i,
  input  logic [NIRQ-1:0]     irq_i,
  input  logic                dram_refresh_en_i,
  input  logic                selfref_ack_i,
  input  logic [SETTLE_W-1:0] settle_cnt_i,
  output logic                run_o,
  output logic                clk_en_o,
  output logic                cpu_clk_en_o,
  output logic [NPERIPH-1:0]  periph_en_o,
  output logic [NPERIPH-1:0]  periph_rst_o,
  output logic                bus_force_low_o,
  output logic                selfref_req_o,
  output logic                dram_en_o
);
  localparam int TO_W  = $clog2(SREF_TO + 1);
  localparam int CNT_W = (SETTLE_W > TO_W) ? SETTLE_W : TO_W;

  pwr_state_e state_q;
  logic       hw_entry_q;   // Standby entered by a hardware reset
  logic       sref_held_q;  // DRAM is parked in self-refresh
  logic       wake_edge, irq_any, stby_exit, cnt_zero;
  logic       cnt_load, cnt_dec;
  logic [CNT_W-1:0] cnt_val;
  pmode_e     pmode;

  assign irq_any   = |irq_i;
  assign stby_exit = wake_edge || (!hw_entry_q && irq_any);

  pwr_wake_sync u_wake (
    .clk_i   (clk_i),
    .rst_n_i (por_n_i),
    .wake_i  (wake_i),
    .edge_o  (wake_edge)
  );

  always_comb begin
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_val  = CNT_W'(SREF_TO - 1);
    if (!user_rst_i) begin
      unique case (state_q)
        ST_OPER:   cnt_load = req_standby_i && dram_refresh_en_i;
        ST_SREF:   cnt_dec  = !selfref_ack_i && !cnt_zero;
        ST_STBY: begin
          cnt_load = stby_exit;
          cnt_val  = CNT_W'(settle_cnt_i);
        end
        ST_SETTLE: cnt_dec  = !cnt_zero;
        default: ;
      endcase
    end
  end

  pwr_down_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_n_i    (por_n_i),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      state_q     <= ST_STBY;
      hw_entry_q  <= 1'b1;
      sref_held_q <= 1'b0;
    end else if (user_rst_i) begin
      state_q     <= ST_STBY;
      hw_entry_q  <= 1'b1;
      sref_held_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_OPER: begin
          if (req_standby_i) begin
            hw_entry_q <= 1'b0;
            if (dram_refresh_en_i) begin
              state_q     <= ST_SREF;
              sref_held_q <= 1'b1;
            end else begin
              state_q <= ST_STBY;
            end
          end else if (req_idle_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE:   if (irq_any) state_q <= ST_OPER;
        ST_SREF:   if (selfref_ack_i || cnt_zero) state_q <= ST_STBY;
        ST_STBY:   if (stby_exit) state_q <= ST_SETTLE;
        ST_SETTLE: begin
          if (cnt_zero) begin
            state_q     <= ST_OPER;
            hw_entry_q  <= 1'b0;
            sref_held_q <= 1'b0;
          end
        end
        default:   state_q <= ST_STBY;
      endcase
    end
  end

  always_comb begin
    if (state_q == ST_STBY || state_q == ST_SETTLE)
      pmode = hw_entry_q ? PM_RESET : PM_STBY;
    else
      pmode = PM_RUN;
  end

  pwr_periph_map u_map (
    .mode_i (pmode),
    .en_o   (periph_en_o),
    .rst_o  (periph_rst_o)
  );

  assign run_o           = (state_q != ST_STBY);
  assign clk_en_o        = (state_q != ST_STBY);
  assign bus_force_low_o = (state_q == ST_STBY);
  assign cpu_clk_en_o    = (state_q == ST_OPER);
  assign selfref_req_o   = (state_q == ST_SREF) ||
                           (sref_held_q && (state_q == ST_STBY || state_q == ST_SETTLE));
  assign dram_en_o       = (state_q != ST_STBY) || sref_held_q;

  // Hardware-reset Standby ignores interrupts.
  assert_cold_irq_ignored_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_STBY && hw_entry_q && !wake_edge && !user_rst_i) |=> state_q == ST_STBY);

  // Standby outputs agree with each other.
  assert_stby_outputs_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (bus_force_low_o == !run_o) && (run_o || !clk_en_o));

  // Self-refresh is requested while the clock still runs.
  assert_sref_first_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_OPER && req_standby_i && dram_refresh_en_i && !user_rst_i)
      |=> (clk_en_o && selfref_req_o));

  // No Idle while a standby sequence is running.
  assert_idle_blocked_R11: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_SREF) |=> state_q != ST_IDLE);

  // Standby beats Idle.
  assert_standby_prio_R12: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_q == ST_OPER && req_standby_i && !user_rst_i) |=> !cpu_clk_en_o && state_q != ST_IDLE);

endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int NIRQ = 4, SETTLE_W = 4, SREF_TO = 8;
  localparam logic [10:0] ALL_EN = 11'h7FF, SB_EN = 11'h700, SB_RST = 11'h002;
  localparam logic [10:0] RS_EN  = 11'h100, RS_RST = 11'h6FF;

  logic clk = 1'b0;
  logic por_n = 1'b0, user_rst = 1'b0, req_idle = 1'b0, req_stby = 1'b0;
  logic wake = 1'b0, refresh = 1'b0, ack = 1'b0;
  logic [NIRQ-1:0] irq = '0;
  logic [SETTLE_W-1:0] settle = '0;
  logic run, clk_en, cpu_en, bus_low, sref_req, dram_en;
  logic [10:0] p_en, p_rst;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.NIRQ(NIRQ), .SETTLE_W(SETTLE_W), .SREF_TO(SREF_TO)) uut (
    .clk_i(clk), .por_n_i(por_n), .user_rst_i(user_rst), .req_idle_i(req_idle),
    .req_standby_i(req_stby), .wake_i(wake), .irq_i(irq), .dram_refresh_en_i(refresh),
    .selfref_ack_i(ack), .settle_cnt_i(settle), .run_o(run), .clk_en_o(clk_en),
    .cpu_clk_en_o(cpu_en), .periph_en_o(p_en), .periph_rst_o(p_rst),
    .bus_force_low_o(bus_low), .selfref_req_o(sref_req), .dram_en_o(dram_en));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_pattern(input string tag, input logic [10:0] en, input logic [10:0] rs);
    chk({tag, " periph_en"}, 32'(p_en), 32'(en));
    chk({tag, " periph_rst"}, 32'(p_rst), 32'(rs));
  endtask

  task automatic t_por;
    por_n = 1'b0;
    #3;
    chk("R1 run", 32'(run), 0);
    chk("R1 clk_en", 32'(clk_en), 0);
    chk("R1 cpu", 32'(cpu_en), 0);
    chk("R1 selfref", 32'(sref_req), 0);
    chk("R1 dram_en", 32'(dram_en), 0);
    chk("R4 bus_low", 32'(bus_low), 1);
    chk_pattern("R1", RS_EN, RS_RST);
    step(1);
    por_n = 1'b1;
    step(3);
    chk("R1 stays standby", 32'(run), 0);
  endtask

  task automatic t_cold_irq;
    irq = 4'b0010;
    step(6);
    chk("R2 irq ignored", 32'(run), 0);
    chk_pattern("R2", RS_EN, RS_RST);
    irq = '0;
  endtask

  task automatic t_cold_wake;
    settle = 4'd3;
    wake = 1'b1;
    step(2);
    chk("R9 not yet", 32'(run), 0);
    step(1);
    chk("R9 exit at k+3", 32'(run), 1);
    chk("R10 clk_en", 32'(clk_en), 1);
    chk("R10 cpu gated", 32'(cpu_en), 0);
    chk_pattern("R10 settle", RS_EN, RS_RST);
    step(3);
    chk("R10 still settling", 32'(cpu_en), 0);
    step(1);
    chk("R10 operating", 32'(cpu_en), 1);
    chk_pattern("R5 run", ALL_EN, 11'h000);
    chk("R10 dram_en", 32'(dram_en), 1);
    settle = '0;
  endtask

  task automatic t_level_held;
    req_stby = 1'b1;
    step(1);
    req_stby = 1'b0;
    chk("R4 run low", 32'(run), 0);
    chk("R4 bus low", 32'(bus_low), 1);
    chk("R4 clk off", 32'(clk_en), 0);
    chk_pattern("R5 standby", SB_EN, SB_RST);
    chk("R5 no selfref", 32'(sref_req), 0);
    chk("R5 dram off", 32'(dram_en), 0);
    step(8);
    chk("R9 held level no wake", 32'(run), 0);
  endtask

  task automatic t_irq_wake;
    irq = 4'b1000;
    step(1);
    irq = '0;
    chk("R3 irq wake", 32'(run), 1);
    chk_pattern("R3 settle", SB_EN, SB_RST);
    step(1);
    chk("R3 operating", 32'(cpu_en), 1);
    wake = 1'b0;
  endtask

  task automatic t_pin_wake_sw;
    step(3);
    req_stby = 1'b1;
    step(1);
    req_stby = 1'b0;
    chk("R3 in standby", 32'(run), 0);
    wake = 1'b1;
    step(2);
    chk("R9 sync delay", 32'(run), 0);
    step(1);
    chk("R3 pin wake", 32'(run), 1);
    step(1);
    chk("R3 pin operating", 32'(cpu_en), 1);
    wake = 1'b0;
  endtask

  task automatic t_idle;
    req_idle = 1'b1;
    step(1);
    req_idle = 1'b0;
    chk("R11 cpu gated", 32'(cpu_en), 0);
    chk("R11 run", 32'(run), 1);
    chk_pattern("R11 idle", ALL_EN, 11'h000);
    step(4);
    chk("R11 stays idle", 32'(cpu_en), 0);
    irq = 4'b0001;
    step(1);
    irq = '0;
    chk("R11 irq exit", 32'(cpu_en), 1);
  endtask

  task automatic t_sref_ack;
    refresh = 1'b1;
    req_stby = 1'b1;
    step(1);
    req_stby = 1'b0;
    chk("R6 selfref req", 32'(sref_req), 1);
    chk("R6 clock kept", 32'(clk_en), 1);
    req_idle = 1'b1;
    step(1);
    req_idle = 1'b0;
    chk("R11 idle ignored", 32'(sref_req & clk_en & ~cpu_en), 1);
    chk("R11 not idle", 32'(run), 1);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R6 clock stopped", 32'(clk_en), 0);
    chk("R6 selfref held", 32'(sref_req), 1);
    chk("R6 dram kept", 32'(dram_en), 1);
    irq = 4'b0100;
    step(1);
    irq = '0;
    chk("R6 selfref in settle", 32'(sref_req), 1);
    step(1);
    chk("R6 selfref dropped", 32'(sref_req), 0);
    chk("R6 operating", 32'(cpu_en), 1);
  endtask

  task automatic t_sref_timeout;
    req_stby = 1'b1;
    step(1);
    req_stby = 1'b0;
    step(SREF_TO - 1);
    chk("R7 before timeout", 32'(clk_en), 1);
    step(1);
    chk("R7 timeout stop", 32'(clk_en), 0);
    chk("R7 selfref", 32'(sref_req), 1);
    irq = 4'b0010;
    step(2);
    irq = '0;
    chk("R7 back", 32'(cpu_en), 1);
    refresh = 1'b0;
  endtask

  task automatic t_prio;
    req_idle = 1'b1;
    req_stby = 1'b1;
    step(1);
    req_idle = 1'b0;
    req_stby = 1'b0;
    chk("R12 standby wins", 32'(run), 0);
    irq = 4'b0001;
    step(2);
    irq = '0;
    chk("R12 back", 32'(cpu_en), 1);
  endtask

  task automatic t_user_rst;
    user_rst = 1'b1;
    step(1);
    user_rst = 1'b0;
    chk("R8 run", 32'(run), 0);
    chk("R8 clk", 32'(clk_en), 0);
    chk("R8 selfref", 32'(sref_req), 1);
    chk("R8 dram_en", 32'(dram_en), 1);
    chk_pattern("R8", RS_EN, RS_RST);
    irq = 4'b1111;
    step(5);
    irq = '0;
    chk("R8 irq ignored", 32'(run), 0);
    wake = 1'b1;
    step(3);
    chk("R8 wake", 32'(run), 1);
    step(1);
    chk("R8 operating", 32'(cpu_en), 1);
    chk("R8 selfref cleared", 32'(sref_req), 0);
    wake = 1'b0;
  endtask

  task automatic t_async_por;
    #1;
    por_n = 1'b0;
    #0.5;
    chk("R1 async run", 32'(run), 0);
    chk("R1 async dram", 32'(dram_en), 0);
    step(1);
    por_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_por();
    t_cold_irq();
    t_cold_wake();
    t_level_held();
    t_irq_wake();
    t_pin_wake_sw();
    t_idle();
    t_sref_ack();
    t_sref_timeout();
    t_prio();
    t_user_rst();
    t_async_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule